// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target that watches oversampled SCL and SDA inputs and answers through a single open-drain enable that pulls SDA low. It recognises START, repeated START and STOP, compares the first byte after a START against a fixed 7-bit address, and acknowledges every byte it accepts by holding SDA low through the ninth clock pulse.

Behind the bus sits a small array of byte registers reached through an internal pointer. In a write transfer, the byte after the address sets the pointer, and each further byte is stored at the pointer, which then advances. In a read transfer the target shifts out the register at the pointer, MSB first, and keeps going as long as the controller acknowledges. The pointer wraps at the end of the array, and a read that does not set the pointer carries on where the last access stopped.

The block has no streaming data port. All data moves over the two bus wires, and the pins are plain levels, so there is no valid/ready back-pressure to describe. SCL and SDA are resynchronised to a system clock that must run several times faster than SCL.

Top module: `i2c_regptr_target`

## Requirements
- R1: After reset the target does not pull SDA low, and every register reads back as 00h.
- R2: A STOP (SDA rising while SCL is high) releases SDA and returns the target to idle. A START or repeated START (SDA falling while SCL is high) begins a new address phase with SDA released.
- R3: An address byte whose upper seven bits are 1101000 (parameter TGT_ADDR = 68h) is acknowledged, with SDA held low for the whole high phase of the ninth pulse. Its bit 0 selects write (0) or read (1).
- R4: An address byte that does not match gets no acknowledge, and the target then ignores the bus until the next START or STOP. Bytes sent in that time are neither acknowledged nor stored.
- R5: In a write, the byte after the address is acknowledged and loads the pointer from its low log2(NREGS) bits. NREGS is a power of two (default 8).
- R6: Each later byte of a write is acknowledged, stored at the pointer, and then advances the pointer by one.
- R7: In a read, the target sends the register at the pointer MSB first, and changes SDA only while SCL is low.
- R8: A read continues with the next register for as long as the controller acknowledges. After a not-acknowledge the target leaves SDA released until the next START or STOP.
- R9: The pointer wraps from NREGS-1 to 0, both when writing and when reading.
- R10: A START or STOP that arrives before the eighth bit of a write byte ends that byte. Nothing is written and the pointer does not move.
- R11: The pointer advances after each byte sent, so a later read that does not set the pointer continues from the following register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level as seen on the wire |
| sda_in | input | 1 | Bus data level as seen on the wire |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 leaves SDA released |

## Verification
The first pattern is a multi-byte write followed by a pointer-only write, a repeated START and a read-back. Read-back data shows whether the first byte after the address was taken as the pointer or as data. A second pattern writes and reads across the top of the array, which separates correct wrap-around from an overrun. A transfer to a foreign address tells ignoring apart from a late acknowledge. Bytes cut short by a STOP and by a repeated START show whether an incomplete byte can still reach the array or move the pointer.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_sense.sv
`timescale 1ns/1ps
// Resynchronises SCL/SDA and derives edges and bus conditions.
module i2c_bus_sense #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_in};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_in};
      scl_p  <= scl_ff[SYNC_N-1];
      sda_p  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_lvl   = scl_ff[SYNC_N-1];
  assign sda_lvl   = sda_ff[SYNC_N-1];
  assign scl_rise  = scl_lvl & ~scl_p;
  assign scl_fall  = ~scl_lvl & scl_p;
  assign start_det = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/i2c_reg_array.sv
`timescale 1ns/1ps
// Plain byte array: one synchronous write port, one combinational read port.
module i2c_reg_array #(
  parameter int NREGS = 8,
  parameter int PW    = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [PW-1:0]                     addr,
  input  logic [i2c_tgt_pkg::BYTE_W-1:0]    wr_data,
  output logic [i2c_tgt_pkg::BYTE_W-1:0]    rd_data
);
  logic [i2c_tgt_pkg::BYTE_W-1:0] mem [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/i2c_tgt_engine.sv
`timescale 1ns/1ps
// Byte-level protocol engine: address match, pointer load, write and read.
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h68,
  parameter int         PW       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [PW-1:0]     ptr,
  output logic              sda_oe,
  output tgt_state_e        state
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic              rw, mack;
  logic              byte_done;

  assign byte_done = scl_fall && (cnt == LAST_BIT);
  assign wr_en     = (state == ST_WDATA) && byte_done && !start_det && !stop_det;
  assign wr_data   = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_lvl};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              if (sh[BYTE_W-1:1] == TGT_ADDR) begin
                rw     <= sh[0];
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end else if (state == ST_PTR) begin
              ptr    <= sh[PW-1:0];
              sda_oe <= 1'b1;
              state  <= ST_PTR_ACK;
            end else begin
              ptr    <= ptr + PW'(1);
              sda_oe <= 1'b1;
              state  <= ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            if (state == ST_ADDR_ACK && rw) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              state  <= ST_RDATA;
            end else if (state == ST_ADDR_ACK) begin
              state <= ST_PTR;
            end else begin
              state <= ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            ptr    <= ptr + PW'(1);
            state  <= ST_RACK;
          end else if (scl_fall) begin
            sh     <= {sh[BYTE_W-2:0], 1'b0};
            sda_oe <= ~sh[BYTE_W-2];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              state  <= ST_RDATA;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regptr_target.sv
`timescale 1ns/1ps
// I2C target with a pointer-addressed byte register array.
module i2c_regptr_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h68,
  parameter int         NREGS    = 8,
  parameter int         SYNC_N   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_drive_low
);
  localparam int PW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic              scl_sync, sda_sync;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [PW-1:0]     ptr;
  tgt_state_e        state;

  i2c_bus_sense #(.SYNC_N(SYNC_N)) u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_lvl  (scl_sync),
    .sda_lvl  (sda_sync),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_tgt_engine #(.TGT_ADDR(TGT_ADDR), .PW(PW)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_lvl  (sda_sync),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ptr      (ptr),
    .sda_oe   (sda_drive_low),
    .state    (state)
  );

  i2c_reg_array #(.NREGS(NREGS), .PW(PW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (ptr),
    .wr_data(wr_data),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/i2c_regptr_chk.sv
`timescale 1ns/1ps
module i2c_regptr_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_drive_low,
  input logic       scl_sync,
  input logic       start_det,
  input logic       stop_det,
  input logic       wr_en,
  input tgt_state_e state
);
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !$past(scl_sync)); // R7

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_drive_low); // R2

  AST_START_NEW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR) && !sda_drive_low); // R2

  AST_WRITE_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_drive_low); // R6

  AST_RACK_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK) |-> !sda_drive_low); // R8

  AST_IGNORE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_drive_low); // R4
endmodule

bind i2c_regptr_target i2c_regptr_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sda_drive_low(sda_drive_low),
  .scl_sync     (scl_sync),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .wr_en        (wr_en),
  .state        (state)
);

// File: tb/test_i2c_regptr_target.sv
`timescale 1ns/1ps
module test_i2c_regptr_target;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_drive_low;
  logic sda_bus;
  bit   done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] got_q[$];

  assign sda_bus = sda_m & ~sda_drive_low;

  always #2.5 clk = ~clk;

  i2c_regptr_target i_i2c_regptr_target (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_m),
    .sda_in       (sda_bus),
    .sda_drive_low(sda_drive_low)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bytes as the bus delivers them
  always @(negedge clk) begin
    logic [7:0] g;
    exp_t e;
    if (got_q.size() > 0) begin
      g = got_q.pop_front();
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected byte", g, 8'h00);
      else begin
        e = exp_q.pop_front();
        check(g == e.val, e.tag, g, e.val);
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(T);
    scl_m = 1'b1; tick(T);
    sda_m = 1'b0; tick(T);
    scl_m = 1'b0; tick(T);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(T);
    scl_m = 1'b1; tick(T);
    sda_m = 1'b1; tick(T);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(T);
    scl_m = 1'b1; tick(T);
    scl_m = 1'b0; tick(T);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit acked);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(T);
    scl_m = 1'b1; tick(1);
    s1 = sda_bus; tick(T - 2);
    s2 = sda_bus; tick(1);
    scl_m = 1'b0; tick(T);
    acked = !s1 && !s2;
  endtask

  task automatic rd_byte(input bit give_ack);
    logic [7:0] v;
    logic s1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(T);
      scl_m = 1'b1; tick(1);
      s1 = sda_bus; tick(T - 2);
      check(sda_bus === s1, "R7 SDA stable while SCL high", {7'd0, sda_bus}, {7'd0, s1});
      v[i] = s1; tick(1);
      scl_m = 1'b0; tick(T);
    end
    got_q.push_back(v);
    sda_m = give_ack ? 1'b0 : 1'b1; tick(T);
    scl_m = 1'b1; tick(T);
    scl_m = 1'b0; tick(T);
    sda_m = 1'b1;
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_t e;
    e.val = v;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send_ok(input logic [7:0] b, input string tag);
    bit a;
    wr_byte(b, a);
    check(a, tag, {7'd0, a}, 8'h01);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    bus_start();
    send_ok(8'hD0, "R3 write address ack");
    send_ok(p, "R5 pointer byte ack");
  endtask

  task automatic begin_read();
    bus_start();
    send_ok(8'hD1, "R3 read address ack");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      summary();
      $finish;
    end
  end

  initial begin
    bit a;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    check(sda_drive_low == 1'b0, "R1 SDA released after reset", {7'd0, sda_drive_low}, 8'h00);

    // R5/R6: pointer then three data bytes
    set_ptr(8'h00);
    send_ok(8'hA5, "R6 data ack");
    send_ok(8'h3C, "R6 data ack");
    send_ok(8'hF0, "R6 data ack");
    bus_stop();
    tick(4);
    check(sda_drive_low == 1'b0, "R2 released after STOP", {7'd0, sda_drive_low}, 8'h00);

    // R2 repeated START into read, R7/R8 continued read, NACK then float
    set_ptr(8'h00);
    begin_read();
    expect_rd(8'hA5, "R7 reg0");
    rd_byte(1'b1);
    expect_rd(8'h3C, "R8 reg1 after ack");
    rd_byte(1'b1);
    expect_rd(8'hF0, "R8 reg2 after ack");
    rd_byte(1'b0);
    expect_rd(8'hFF, "R8 released after NACK");
    rd_byte(1'b0);
    bus_stop();

    // R1: untouched registers read zero
    set_ptr(8'h03);
    begin_read();
    expect_rd(8'h00, "R1 reg3 reset value");
    rd_byte(1'b1);
    expect_rd(8'h00, "R1 reg4 reset value");
    rd_byte(1'b0);
    bus_stop();

    // R9: write wrap 6,7,0
    set_ptr(8'h06);
    send_ok(8'h11, "R6 data ack");
    send_ok(8'h22, "R6 data ack");
    send_ok(8'h33, "R9 wrapped write ack");
    bus_stop();
    set_ptr(8'h07);
    begin_read();
    expect_rd(8'h22, "R9 reg7");
    rd_byte(1'b1);
    expect_rd(8'h33, "R9 read wraps to reg0");
    rd_byte(1'b1);
    expect_rd(8'h3C, "R9 reg1 after wrap");
    rd_byte(1'b0);
    bus_stop();

    // R11: new read continues at reg2
    begin_read();
    expect_rd(8'hF0, "R11 read continues from pointer");
    rd_byte(1'b0);
    bus_stop();

    // R5: pointer uses low bits only (0Ah -> 2)
    set_ptr(8'h0A);
    begin_read();
    expect_rd(8'hF0, "R5 pointer low bits");
    rd_byte(1'b0);
    bus_stop();

    // R4: foreign address ignored
    bus_start();
    wr_byte(8'hA0, a);
    check(!a, "R4 no ack for foreign address", {7'd0, a}, 8'h00);
    wr_byte(8'h00, a);
    check(!a, "R4 no ack while ignoring", {7'd0, a}, 8'h00);
    wr_byte(8'h99, a);
    check(!a, "R4 no ack while ignoring", {7'd0, a}, 8'h00);
    bus_stop();
    set_ptr(8'h00);
    begin_read();
    expect_rd(8'h33, "R4 reg0 unchanged");
    rd_byte(1'b0);
    bus_stop();

    // R10: byte cut short by STOP
    set_ptr(8'h04);
    send_ok(8'h77, "R6 data ack");
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    set_ptr(8'h04);
    begin_read();
    expect_rd(8'h77, "R6 reg4 written");
    rd_byte(1'b1);
    expect_rd(8'h00, "R10 STOP-aborted byte not written");
    rd_byte(1'b0);
    bus_stop();

    // R10: byte cut short by repeated START keeps pointer
    set_ptr(8'h05);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    begin_read();
    expect_rd(8'h00, "R10 START-aborted byte, pointer unmoved");
    rd_byte(1'b0);
    bus_stop();

    tick(20);
    check(exp_q.size() == 0, "R7 all expected bytes seen", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule